// File: doc/BRIEF.md
# Decoded-Instruction Filter Cache with Fetch-Source Predictor

This block sits in a processor front end beside the instruction cache and the decoder. It keeps a small direct-mapped store of instructions that have already been decoded. When a fetch hits in this store, the front end gets the decoded micro-word directly and skips both the instruction-cache read and the decode stage. The store has 32 sectors. Each sector holds four consecutive decoded instructions of 64 bits each, along with a tag, a per-slot fill mask, a sector-valid bit and a recorded follower address. Architectural instructions are 4 bytes wide, so one sector covers 16 bytes of fetch address space.

A fetch-source predictor works from tag locality. It compares the tag of each fetch with the tag of the fetch before it. Matching tags suggest a tight loop, so the next fetch is sent to the filter store. Differing tags suggest a change of control path, so the next fetch is sent to the instruction cache. A fetch that was steered to the store but misses there raises a mispredict pulse and hands back its address, so the pipeline can reissue it to the instruction cache. The decoder refills the store one decoded instruction per cycle. A flush empties the store and resets the predictor. Three event counters track store accesses, hits and misses.

Top module: `dec_filter_cache`

## Requirements
- R1: After reset, no response is valid, the predicted source is the instruction cache (`pred_buf`=0), and all three counters read zero.
- R2: Fetch and fill addresses are split as follows: bits [1:0] are the byte offset, bits [3:2] select the slot within a sector, bits [8:4] select one of 32 sectors, and bits [31:9] form the tag.
- R3: Each cycle with `fill_valid` writes one decoded word into the addressed slot. If the fill tag differs from the tag stored in that sector, the sector takes the new tag and its slot mask is cleared before this write. A sector becomes valid only once all 4 slots have been written under one tag.
- R4: A fetch steered to the store hits when the indexed sector is valid and its tag matches. The registered response in the following cycle carries `resp_hit`=1 and the decoded word of the addressed slot.
- R5: `pred_buf` is 1 after a fetch whose tag equals the tag of the fetch just before it. It is 0 after a fetch whose tag differs. It is 0 after the first fetch following reset or flush. Each fetch is served from the source predicted before it arrives, and `resp_buf` reports that source.
- R6: A fetch steered to the store that misses raises `mispredict` together with its response. `reissue_addr` then holds the fetch address, to be sent to the instruction cache.
- R7: A fetch steered to the instruction cache does not consult the store. It returns `resp_hit`=0 and `mispredict`=0, and it leaves all counters unchanged.
- R8: Each sector records the address of the fetch that followed its most recent access. A hit response returns this address in `resp_next` as it stood before the current fetch.
- R9: A flush clears every sector-valid bit and every slot mask, returns the predictor to the instruction cache with no previous fetch, and cancels any fetch presented in the same cycle.
- R10: `cnt_access` counts fetches steered to the store, and `cnt_hit` and `cnt_miss` count their outcomes. These counters update in the same edge as the response, and `cnt_access` always equals `cnt_hit`+`cnt_miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the store and reset the predictor |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_addr | input | 32 | Byte address of the fetch |
| fill_valid | input | 1 | Decoder writes one decoded word this cycle |
| fill_addr | input | 32 | Byte address of the instruction being filled |
| fill_word | input | 64 | Decoded micro-word being filled |
| resp_valid | output | 1 | Response for the fetch of the previous cycle |
| resp_buf | output | 1 | The fetch was steered to the store |
| resp_hit | output | 1 | The store supplied the decoded word |
| resp_word | output | 64 | Decoded word, meaningful on a hit |
| resp_next | output | 32 | Recorded follower address of the hit sector |
| mispredict | output | 1 | Store-steered fetch missed, reissue needed |
| reissue_addr | output | 32 | Address to refetch from the instruction cache |
| pred_buf | output | 1 | Predicted source of the next fetch (1 = store) |
| cnt_access | output | 32 | Store access count |
| cnt_hit | output | 32 | Store hit count |
| cnt_miss | output | 32 | Store miss count |

## Verification
The fetch streams are built so that the tag of the previous fetch decides the source. A run of same-tag fetches shows the predictor switching to the store. A fetch with a new tag tells a correct store hit apart from a correctly declined store access. Partially filled sectors, and a sector whose tag was overwritten by an aliasing address, separate a true hit from a tag-only match or a slot-only match. A fetch stream that runs across a flush and a refill shows that valid state is cleared while the follower addresses and counters survive as specified.

// File: rtl/dfc_pkg.sv
// Shared constants and types for the decoded-instruction filter cache.
// Assumes byte addressing with fixed-size architectural instructions.
package dfc_pkg;
    parameter int DFC_ADDR_W   = 32;
    parameter int DFC_WORD_W   = 64;
    parameter int DFC_SECTORS  = 32;
    parameter int DFC_SLOTS    = 4;
    parameter int DFC_INSTR_B  = 4;
    parameter int DFC_CNT_W    = 32;

    // Source a fetch is steered to.
    typedef enum logic {
        SRC_ICACHE = 1'b0,
        SRC_BUF    = 1'b1
    } fetch_src_e;
endpackage

// File: rtl/dfc_tag_array.sv
// Per-sector control state: tag, slot fill mask, sector-valid and the
// recorded follower address. One read port (combinational on registered
// state), one fill port, one follower-address write port.
// Assumes at most one fill and one follower write per cycle.
module dfc_tag_array #(
    parameter int SECTORS = 32,
    parameter int SLOTS   = 4,
    parameter int TAG_W   = 23,
    parameter int AW      = 32,
    localparam int IDX_W  = $clog2(SECTORS),
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              nxt_we,
    input  logic [IDX_W-1:0]  nxt_idx,
    input  logic [AW-1:0]     nxt_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic [AW-1:0]     rd_next
);
    logic [TAG_W-1:0] tag_q   [SECTORS];
    logic [SLOTS-1:0] mask_q  [SECTORS];
    logic             valid_q [SECTORS];
    logic [AW-1:0]    next_q  [SECTORS];

    logic [SLOTS-1:0] fill_onehot;

    // Decode the fill slot into a one-hot write mask.
    always_comb begin
        fill_onehot = '0;
        fill_onehot[fill_slot] = 1'b1;
    end

    for (genvar s = 0; s < SECTORS; s++) begin : g_sector
        logic sel_fill;
        logic sel_next;
        logic tag_same;
        logic [SLOTS-1:0] mask_nx;

        assign sel_fill = fill_en && (fill_idx == IDX_W'(s));
        assign sel_next = nxt_we && (nxt_idx == IDX_W'(s));
        assign tag_same = (tag_q[s] == fill_tag);
        assign mask_nx  = tag_same ? (mask_q[s] | fill_onehot) : fill_onehot;

        // Sector fill state: retag clears the mask, full mask sets valid.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[s]   <= '0;
                mask_q[s]  <= '0;
                valid_q[s] <= 1'b0;
            end else if (flush) begin
                mask_q[s]  <= '0;
                valid_q[s] <= 1'b0;
            end else if (sel_fill) begin
                tag_q[s]   <= fill_tag;
                mask_q[s]  <= mask_nx;
                valid_q[s] <= &mask_nx;
            end
        end

        // Follower address: kept across flush, cleared only by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                next_q[s] <= '0;
            end else if (sel_next && !flush) begin
                next_q[s] <= nxt_addr;
            end
        end
    end

    assign rd_tag   = tag_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_next  = next_q[rd_idx];
endmodule

// File: rtl/dfc_data_array.sv
// Storage for decoded micro-words, SECTORS x SLOTS entries.
// Assumes validity is tracked elsewhere, so the words carry no reset.
module dfc_data_array #(
    parameter int SECTORS = 32,
    parameter int SLOTS   = 4,
    parameter int WORD_W  = 64,
    localparam int IDX_W  = $clog2(SECTORS),
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int ENT_W  = IDX_W + SLOT_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [WORD_W-1:0] rd_word
);
    localparam int ENTRIES = SECTORS * SLOTS;

    logic [WORD_W-1:0] mem_q [ENTRIES];
    logic [ENT_W-1:0]  wr_ent;
    logic [ENT_W-1:0]  rd_ent;

    assign wr_ent = {wr_idx, wr_slot};
    assign rd_ent = {rd_idx, rd_slot};

    // Write one decoded word per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_ent] <= wr_word;
        end
    end

    assign rd_word = mem_q[rd_ent];
endmodule

// File: rtl/dfc_predictor.sv
// Fetch-source predictor. Remembers the tag and sector of the previous
// fetch and steers the next fetch to the store when two consecutive
// fetches share a tag. Assumes fetch_go already excludes flush cycles.
module dfc_predictor
    import dfc_pkg::*;
#(
    parameter int TAG_W = 23,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fetch_go,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic [IDX_W-1:0] cur_idx,
    output fetch_src_e       src_q,
    output logic             last_valid,
    output logic [IDX_W-1:0] last_idx
);
    logic [TAG_W-1:0] last_tag;
    fetch_src_e       src_nx;

    // Choose the source for the fetch after the current one.
    always_comb begin
        src_nx = (last_valid && (last_tag == cur_tag)) ? SRC_BUF : SRC_ICACHE;
    end

    // Track the previous fetch and the resulting prediction.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            src_q      <= SRC_ICACHE;
            last_valid <= 1'b0;
            last_tag   <= '0;
            last_idx   <= '0;
        end else if (fetch_go) begin
            src_q      <= src_nx;
            last_valid <= 1'b1;
            last_tag   <= cur_tag;
            last_idx   <= cur_idx;
        end
    end
endmodule

// File: rtl/dfc_event_ctr.sv
// Free-running event counter with synchronous reset; wraps at full scale.
module dfc_event_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Count one event per cycle at most.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end
endmodule

// File: rtl/dec_filter_cache.sv
// Top of the decoded-instruction filter cache. Splits the fetch address,
// looks up the sector, registers the response one cycle later and updates
// the fetch-source predictor and follower addresses.
// Assumes the fetch and fill paths are independent: a fill in the same cycle
// as a fetch to the same sector becomes visible to the next fetch only.
module dec_filter_cache
    import dfc_pkg::*;
#(
    parameter int AW      = DFC_ADDR_W,
    parameter int WORD_W  = DFC_WORD_W,
    parameter int SECTORS = DFC_SECTORS,
    parameter int SLOTS   = DFC_SLOTS,
    parameter int INSTR_B = DFC_INSTR_B,
    parameter int CNT_W   = DFC_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fetch_valid,
    input  logic [AW-1:0]     fetch_addr,
    input  logic              fill_valid,
    input  logic [AW-1:0]     fill_addr,
    input  logic [WORD_W-1:0] fill_word,
    output logic              resp_valid,
    output logic              resp_buf,
    output logic              resp_hit,
    output logic [WORD_W-1:0] resp_word,
    output logic [AW-1:0]     resp_next,
    output logic              mispredict,
    output logic [AW-1:0]     reissue_addr,
    output logic              pred_buf,
    output logic [CNT_W-1:0]  cnt_access,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss
);
    localparam int OFS_W   = $clog2(INSTR_B);
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int IDX_W   = $clog2(SECTORS);
    localparam int IDX_LSB = OFS_W + SLOT_W;
    localparam int TAG_LSB = IDX_LSB + IDX_W;
    localparam int TAG_W   = AW - TAG_LSB;

    // Address fields of the fetch and the fill.
    logic [SLOT_W-1:0] f_slot, w_slot;
    logic [IDX_W-1:0]  f_idx,  w_idx;
    logic [TAG_W-1:0]  f_tag,  w_tag;

    assign f_slot = fetch_addr[OFS_W +: SLOT_W];
    assign f_idx  = fetch_addr[IDX_LSB +: IDX_W];
    assign f_tag  = fetch_addr[AW-1:TAG_LSB];
    assign w_slot = fill_addr[OFS_W +: SLOT_W];
    assign w_idx  = fill_addr[IDX_LSB +: IDX_W];
    assign w_tag  = fill_addr[AW-1:TAG_LSB];

    wire unused_fill_ofs = ^fill_addr[OFS_W-1:0];

    logic              fetch_go;
    logic              fill_go;
    fetch_src_e        src_q;
    logic              last_valid;
    logic [IDX_W-1:0]  last_idx;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_valid;
    logic [AW-1:0]     rd_next;
    logic [WORD_W-1:0] rd_word;
    logic              lookup_hit;
    logic              buf_try;
    logic              ev_hit;
    logic              ev_miss;

    assign fetch_go   = fetch_valid && !flush;
    assign fill_go    = fill_valid && !flush;
    assign lookup_hit = rd_valid && (rd_tag == f_tag);
    assign buf_try    = fetch_go && (src_q == SRC_BUF);
    assign ev_hit     = buf_try && lookup_hit;
    assign ev_miss    = buf_try && !lookup_hit;
    assign pred_buf   = (src_q == SRC_BUF);

    dfc_tag_array #(
        .SECTORS (SECTORS),
        .SLOTS   (SLOTS),
        .TAG_W   (TAG_W),
        .AW      (AW)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .fill_en   (fill_go),
        .fill_idx  (w_idx),
        .fill_slot (w_slot),
        .fill_tag  (w_tag),
        .nxt_we    (fetch_go && last_valid),
        .nxt_idx   (last_idx),
        .nxt_addr  (fetch_addr),
        .rd_idx    (f_idx),
        .rd_tag    (rd_tag),
        .rd_valid  (rd_valid),
        .rd_next   (rd_next)
    );

    dfc_data_array #(
        .SECTORS (SECTORS),
        .SLOTS   (SLOTS),
        .WORD_W  (WORD_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (fill_go),
        .wr_idx  (w_idx),
        .wr_slot (w_slot),
        .wr_word (fill_word),
        .rd_idx  (f_idx),
        .rd_slot (f_slot),
        .rd_word (rd_word)
    );

    dfc_predictor #(
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) u_pred (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fetch_go   (fetch_go),
        .cur_tag    (f_tag),
        .cur_idx    (f_idx),
        .src_q      (src_q),
        .last_valid (last_valid),
        .last_idx   (last_idx)
    );

    // Register the response one cycle after the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_buf     <= 1'b0;
            resp_hit     <= 1'b0;
            resp_word    <= '0;
            resp_next    <= '0;
            mispredict   <= 1'b0;
            reissue_addr <= '0;
        end else begin
            resp_valid   <= fetch_go;
            resp_buf     <= buf_try;
            resp_hit     <= ev_hit;
            resp_word    <= ev_hit ? rd_word : '0;
            resp_next    <= ev_hit ? rd_next : '0;
            mispredict   <= ev_miss;
            reissue_addr <= fetch_go ? fetch_addr : reissue_addr;
        end
    end

    dfc_event_ctr #(.CNT_W(CNT_W)) u_ctr_acc (
        .clk (clk), .rst_n (rst_n), .inc (buf_try), .count (cnt_access)
    );
    dfc_event_ctr #(.CNT_W(CNT_W)) u_ctr_hit (
        .clk (clk), .rst_n (rst_n), .inc (ev_hit), .count (cnt_hit)
    );
    dfc_event_ctr #(.CNT_W(CNT_W)) u_ctr_miss (
        .clk (clk), .rst_n (rst_n), .inc (ev_miss), .count (cnt_miss)
    );
endmodule

// File: rtl/dec_filter_cache_chk.sv
// Protocol checker for the filter cache, attached by bind. Observes only
// the top-level ports.
module dec_filter_cache_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             fetch_valid,
    input logic             pred_buf,
    input logic             resp_valid,
    input logic             resp_buf,
    input logic             resp_hit,
    input logic             mispredict,
    input logic [CNT_W-1:0] cnt_access,
    input logic [CNT_W-1:0] cnt_hit,
    input logic [CNT_W-1:0] cnt_miss
);
    // R4: a hit only comes from a valid store-steered response.
    p_hit_from_buf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (resp_valid && resp_buf));

    // R6: a mispredict is a store-steered response without a hit.
    p_mis_is_buf_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> (resp_valid && resp_buf && !resp_hit));

    // R7: a cache-steered response never hits nor mispredicts.
    p_icache_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_buf) |-> (!resp_hit && !mispredict));

    // R5: the prediction can only turn to the store after a fetch.
    p_pred_after_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pred_buf) |-> $past(fetch_valid));

    // R9: flush leaves the predictor on the cache and no response.
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!pred_buf && !resp_valid));

    // R10: accesses equal hits plus misses.
    p_cnt_balance_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_access} == ({1'b0, cnt_hit} + {1'b0, cnt_miss})));

    // R10: the access counter moves by at most one per cycle.
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_access == $past(cnt_access)) ||
        (cnt_access == $past(cnt_access) + CNT_W'(1)));
endmodule

bind dec_filter_cache dec_filter_cache_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_valid (fetch_valid),
    .pred_buf    (pred_buf),
    .resp_valid  (resp_valid),
    .resp_buf    (resp_buf),
    .resp_hit    (resp_hit),
    .mispredict  (mispredict),
    .cnt_access  (cnt_access),
    .cnt_hit     (cnt_hit),
    .cnt_miss    (cnt_miss)
);

// File: tb/dec_filter_cache_bench.sv
// Directed bench for the filter cache: one task per scenario.
module dec_filter_cache_bench;
    localparam int AW = 32;
    localparam int WW = 64;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic [WW-1:0] fill_word = '0;
    logic          resp_valid, resp_buf, resp_hit, mispredict, pred_buf;
    logic [WW-1:0] resp_word;
    logic [AW-1:0] resp_next, reissue_addr;
    logic [CW-1:0] cnt_access, cnt_hit, cnt_miss;

    int n_tests = 0;
    int n_fail  = 0;
    int e_acc = 0, e_hit = 0, e_miss = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dec_filter_cache u_dec_filter_cache (
        .clk (clk), .rst_n (rst_n), .flush (flush),
        .fetch_valid (fetch_valid), .fetch_addr (fetch_addr),
        .fill_valid (fill_valid), .fill_addr (fill_addr), .fill_word (fill_word),
        .resp_valid (resp_valid), .resp_buf (resp_buf), .resp_hit (resp_hit),
        .resp_word (resp_word), .resp_next (resp_next),
        .mispredict (mispredict), .reissue_addr (reissue_addr),
        .pred_buf (pred_buf),
        .cnt_access (cnt_access), .cnt_hit (cnt_hit), .cnt_miss (cnt_miss)
    );

    function automatic logic [WW-1:0] word_of(input logic [AW-1:0] a);
        return {a, a ^ 32'hA5C3_0F00};
    endfunction

    task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                         input logic [WW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_fill(input logic [AW-1:0] a);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_word = word_of(a);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Present one fetch and check the registered response.
    task automatic do_fetch(input logic [AW-1:0] a, input bit eb, input bit eh,
                            input logic [AW-1:0] en, input bit ep);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        if (eb) e_acc++;
        if (eb && eh) e_hit++;
        if (eb && !eh) e_miss++;
        check(resp_valid == 1'b1, "R4 resp_valid", WW'(resp_valid), 1);
        check(resp_buf == eb, "R5 resp_buf", WW'(resp_buf), WW'(eb));
        check(resp_hit == eh, "R4 resp_hit", WW'(resp_hit), WW'(eh));
        check(mispredict == (eb && !eh), "R6 mispredict", WW'(mispredict), WW'(eb && !eh));
        if (eb && !eh)
            check(reissue_addr == a, "R6 reissue_addr", WW'(reissue_addr), WW'(a));
        if (eh) begin
            check(resp_word == word_of(a), "R4 resp_word", resp_word, word_of(a));
            check(resp_next == en, "R8 resp_next", WW'(resp_next), WW'(en));
        end
        check(pred_buf == ep, "R5 pred_buf", WW'(pred_buf), WW'(ep));
    endtask

    task automatic check_counters(input string req);
        check(cnt_access == CW'(e_acc), req, WW'(cnt_access), WW'(e_acc));
        check(cnt_hit == CW'(e_hit), req, WW'(cnt_hit), WW'(e_hit));
        check(cnt_miss == CW'(e_miss), req, WW'(cnt_miss), WW'(e_miss));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(resp_valid == 1'b0, "R1 resp_valid", WW'(resp_valid), 0);
        check(pred_buf == 1'b0, "R1 pred_buf", WW'(pred_buf), 0);
        check_counters("R1 counters");
    endtask

    // Loop in one sector: predictor turns to the store, hits return words.
    task automatic t_loop_hits();
        for (int i = 0; i < 4; i++) do_fill(32'h100 + 32'(i * 4));
        do_fetch(32'h100, 0, 0, 0, 0);      // R5 first fetch after reset
        do_fetch(32'h104, 0, 0, 0, 1);      // R5 same tag -> store next
        do_fetch(32'h108, 1, 1, 32'h104, 1); // R4 R2 R8
        do_fetch(32'h10C, 1, 1, 32'h108, 1); // R8
        check_counters("R10 after loop");
    endtask

    // Partially filled sector misses until its last slot is written.
    task automatic t_partial_fill();
        for (int i = 0; i < 3; i++) do_fill(32'h200 + 32'(i * 4));
        do_fetch(32'h200, 1, 0, 0, 0);      // R3 not yet valid, R6
        do_fetch(32'h204, 0, 0, 0, 1);
        do_fetch(32'h208, 1, 0, 0, 1);      // R3 R6 slot written but sector invalid
        do_fill(32'h20C);
        do_fetch(32'h20C, 1, 1, 32'h208, 1); // R3 now valid
        do_fetch(32'h200, 1, 1, 32'h20C, 1); // R2 slot 0 word
    endtask

    // Aliasing fill with a new tag clears the sector; tag change redirects.
    task automatic t_retag();
        do_fill(32'h1200);                  // R2 R3 same index 0, tag 9
        do_fetch(32'h204, 1, 0, 0, 1);      // R3 tag mismatch -> mispredict
        do_fetch(32'h100, 1, 1, 32'h200, 0); // R8 R5 tag changed
        do_fetch(32'h104, 0, 0, 0, 1);      // R7 cache-steered, not counted
        check_counters("R7 R10 counters");
    endtask

    // Flush empties the store and the predictor; follower addresses remain.
    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1; fetch_valid = 1'b1; fetch_addr = 32'h108;
        @(negedge clk);
        flush = 1'b0; fetch_valid = 1'b0;
        check(pred_buf == 1'b0, "R9 pred_buf", WW'(pred_buf), 0);
        check(resp_valid == 1'b0, "R9 fetch cancelled", WW'(resp_valid), 0);
        do_fetch(32'h108, 0, 0, 0, 0);      // R9 no previous fetch
        do_fetch(32'h10C, 0, 0, 0, 1);
        do_fetch(32'h100, 1, 0, 0, 1);      // R9 sector invalid after flush
        for (int i = 0; i < 4; i++) do_fill(32'h100 + 32'(i * 4));
        do_fetch(32'h104, 1, 1, 32'h100, 1); // R8 R9 refill
        check_counters("R10 final");
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_loop_hits();
        t_partial_fill();
        t_retag();
        t_flush();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule